// File: doc/BRIEF.md
# Flag-Conditioned Microcode Sequencer

This block is the control sequencer of a small 8-bit accumulator machine. An internal 2-bit micro-step counter runs through four steps per instruction. On every cycle the block combines three inputs into a 9-bit table address: the latched status flags (carry, sign, zero), the 4-bit opcode held in the instruction register, and the current step. It then drives an 18-bit control word, with one bit per datapath strobe. The word includes a load enable for the flag register.

The table has 512 entries and is computed at elaboration. A base table of 16 opcodes by 4 steps is repeated once for each of the eight flag combinations. In every copy where a conditional jump's own flag is set, that jump's entries are replaced by the unconditional-jump sequence. Branching therefore costs no comparator and adds no extra cycle. A conditional jump whose flag is clear runs as a no-op.

When the halt strobe is asserted, the step counter stops and the machine stays on that word until the opcode changes or reset is applied.

Top module: `ucode_ctrl`

## Requirements
- R1: `rst_n` low forces `step` to 0 at once, without waiting for a clock. After `rst_n` rises, `step` stays 0 through the next two rising clock edges and first advances on the third.
- R2: Outside reset and with `ctrl[17]` (halt) low, `step` increments by one on each rising edge and wraps from 3 to 0.
- R3: While `ctrl[17]` is high, `step` holds its value across clock edges.
- R4: For every opcode and every flag value, step 0 emits bits {2,16} (pc_out, mar_ld), i.e. 18'h10004. Step 1 emits bits {14,11,1} (ram_rd, ir_ld, pc_inc), i.e. 18'h04802.
- R5: Bit positions, MSB to LSB, are: 17 halt, 16 mar_ld, 15 ram_wr, 14 ram_rd, 13 flag_ld, 12 ir_out, 11 ir_ld, 10 out_ld, 9 out_signed, 8 alu_sub, 7 alu_out, 6 b_out, 5 b_ld, 4 a_out, 3 a_ld, 2 pc_out, 1 pc_inc, 0 pc_ld. Steps 2 and 3 for the other opcodes are:
  - 0 nop: 0, 0
  - 1 load A from memory: ir_out|mar_ld, then ram_rd|a_ld
  - 2 load A immediate: ir_out|a_ld, then 0
  - 3 load B from memory: ir_out|mar_ld, then ram_rd|b_ld
  - 4 load B immediate: ir_out|b_ld, then 0
  - 5 store A: ir_out|mar_ld, then a_out|ram_wr
  - 6 store B: ir_out|mar_ld, then b_out|ram_wr
  - 13 output unsigned: ir_out|mar_ld, then ram_rd|out_ld
  - 14 output signed: ir_out|mar_ld, then ram_rd|out_ld|out_signed
  - 15 halt: halt, then 0
- R6: Opcode 7 (add) emits alu_out|a_ld|flag_ld at step 2. Opcode 8 (subtract) emits alu_out|alu_sub|a_ld|flag_ld at step 2. Both emit 0 at step 3. flag_ld is never high in any other word.
- R7: Opcode 9 (jump) emits ir_out|pc_ld (18'h01001) at step 2 and 0 at step 3.
- R8: Opcodes 10, 11 and 12 (jump on zero, on sign, on carry) emit the same words as opcode 9 when `flag_z`, `flag_s` or `flag_c` respectively is high, whatever the other two flags are.
- R9: When the tested flag is low, opcodes 10, 11 and 12 emit 0 at steps 2 and 3.
- R10: The flag inputs have no effect on the control word of any opcode other than 10, 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 4 | Opcode from the instruction register |
| flag_c | input | 1 | Latched carry flag |
| flag_s | input | 1 | Latched sign flag |
| flag_z | input | 1 | Latched zero flag |
| step | output | 2 | Current micro-step |
| ctrl | output | 18 | Control word, bit order as in R5 |

## Verification
The hardest entries to reach are the rows where a conditional jump's outcome depends on one flag while the other two carry arbitrary values. The flags are inputs here, so the bench drives each of the three conditional jumps through a full instruction under all eight flag combinations. This covers every taken and not-taken copy of the table. The halt freeze is reached by holding the halt opcode past step 2 and then switching to a no-op to show that the counter resumes. A second reset is applied asynchronously in the middle of an instruction to exercise the early clear and the two-edge release.

// File: rtl/ucode_ctrl_pkg.sv
package ucode_ctrl_pkg;

  localparam int OP_W   = 4;
  localparam int STEP_W = 2;
  localparam int FLAG_W = 3;
  localparam int CW_W   = 18;
  localparam int ADDR_W = FLAG_W + OP_W + STEP_W;

  typedef logic [CW_W-1:0] cword_t;

  // control bit positions (decoded by the datapath)
  localparam int B_HALT    = 17;
  localparam int B_MAR_LD  = 16;
  localparam int B_RAM_WR  = 15;
  localparam int B_RAM_RD  = 14;
  localparam int B_FLAG_LD = 13;
  localparam int B_IR_OUT  = 12;
  localparam int B_IR_LD   = 11;
  localparam int B_OUT_LD  = 10;
  localparam int B_OUT_SGN = 9;
  localparam int B_ALU_SUB = 8;
  localparam int B_ALU_OUT = 7;
  localparam int B_B_OUT   = 6;
  localparam int B_B_LD    = 5;
  localparam int B_A_OUT   = 4;
  localparam int B_A_LD    = 3;
  localparam int B_PC_OUT  = 2;
  localparam int B_PC_INC  = 1;
  localparam int B_PC_LD   = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0, OP_LDA_M = 4'h1, OP_LDA_I = 4'h2, OP_LDB_M = 4'h3,
    OP_LDB_I = 4'h4, OP_STA   = 4'h5, OP_STB   = 4'h6, OP_ADD   = 4'h7,
    OP_SUB   = 4'h8, OP_JMP   = 4'h9, OP_JZ    = 4'hA, OP_JS    = 4'hB,
    OP_JC    = 4'hC, OP_OUTU  = 4'hD, OP_OUTS  = 4'hE, OP_HLT   = 4'hF
  } opcode_e;

  function automatic cword_t sig(input int b);
    return cword_t'(1) << b;
  endfunction

  // unconditional microcode for one opcode and step
  function automatic cword_t base_word(input logic [OP_W-1:0] op,
                                       input logic [STEP_W-1:0] st);
    cword_t w;
    w = '0;
    if (st == 2'd0) begin
      w = sig(B_PC_OUT) | sig(B_MAR_LD);
    end else if (st == 2'd1) begin
      w = sig(B_RAM_RD) | sig(B_IR_LD) | sig(B_PC_INC);
    end else if (st == 2'd2) begin
      case (opcode_e'(op))
        OP_LDA_M, OP_LDB_M, OP_STA, OP_STB, OP_OUTU, OP_OUTS:
                  w = sig(B_IR_OUT) | sig(B_MAR_LD);
        OP_LDA_I: w = sig(B_IR_OUT) | sig(B_A_LD);
        OP_LDB_I: w = sig(B_IR_OUT) | sig(B_B_LD);
        OP_ADD:   w = sig(B_ALU_OUT) | sig(B_A_LD) | sig(B_FLAG_LD);
        OP_SUB:   w = sig(B_ALU_OUT) | sig(B_ALU_SUB) | sig(B_A_LD) | sig(B_FLAG_LD);
        OP_JMP:   w = sig(B_IR_OUT) | sig(B_PC_LD);
        OP_HLT:   w = sig(B_HALT);
        default:  w = '0;
      endcase
    end else begin
      case (opcode_e'(op))
        OP_LDA_M: w = sig(B_RAM_RD) | sig(B_A_LD);
        OP_LDB_M: w = sig(B_RAM_RD) | sig(B_B_LD);
        OP_STA:   w = sig(B_A_OUT) | sig(B_RAM_WR);
        OP_STB:   w = sig(B_B_OUT) | sig(B_RAM_WR);
        OP_OUTU:  w = sig(B_RAM_RD) | sig(B_OUT_LD);
        OP_OUTS:  w = sig(B_RAM_RD) | sig(B_OUT_LD) | sig(B_OUT_SGN);
        default:  w = '0;
      endcase
    end
    return w;
  endfunction

  // full table entry: address = {C, S, Z, opcode, step}
  function automatic cword_t table_word(input logic [ADDR_W-1:0] a);
    logic [FLAG_W-1:0] fl;
    logic [OP_W-1:0]   op;
    logic [STEP_W-1:0] st;
    logic              taken;
    fl = a[ADDR_W-1 -: FLAG_W];
    op = a[STEP_W +: OP_W];
    st = a[STEP_W-1:0];
    taken = (op == OP_JZ && fl[0]) || (op == OP_JS && fl[1]) ||
            (op == OP_JC && fl[2]);
    return base_word(taken ? OP_JMP : op, st);
  endfunction

endpackage

// File: rtl/ucode_rst_sync.sv
module ucode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ucode_step_ctr.sv
module ucode_step_ctr #(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic              step_en;

  always_comb begin
    step_en = !hold;
    step_d  = step_q + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom #(
  parameter int ADDR_W = ucode_ctrl_pkg::ADDR_W,
  parameter int CW_W   = ucode_ctrl_pkg::CW_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CW_W-1:0]   word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = CW_W'(ucode_ctrl_pkg::table_word(ucode_ctrl_pkg::ADDR_W'(g)));
  end

  assign word = tbl[addr];
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl #(
  parameter int OP_W   = ucode_ctrl_pkg::OP_W,
  parameter int STEP_W = ucode_ctrl_pkg::STEP_W,
  parameter int CW_W   = ucode_ctrl_pkg::CW_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic              flag_c,
  input  logic              flag_s,
  input  logic              flag_z,
  output logic [STEP_W-1:0] step,
  output logic [CW_W-1:0]   ctrl
);
  localparam int FLAG_W = 3;
  localparam int ADDR_W = FLAG_W + OP_W + STEP_W;

  logic              rst_sync_n;
  logic [STEP_W-1:0] step_w;
  logic [ADDR_W-1:0] rom_addr;
  logic [CW_W-1:0]   rom_word;

  ucode_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ucode_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_sync_n), .hold(rom_word[CW_W-1]), .step(step_w)
  );

  assign rom_addr = {flag_c, flag_s, flag_z, opcode, step_w};

  ucode_rom #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_rom (
    .addr(rom_addr), .word(rom_word)
  );

  assign step = step_w;
  assign ctrl = rom_word;
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk (
  input logic       clk,
  input logic       rst_i,
  input logic [3:0] opcode,
  input logic       flag_c,
  input logic       flag_s,
  input logic       flag_z,
  input logic [1:0] step,
  input logic [17:0] ctrl
);
  localparam logic [17:0] W_FETCH0 = 18'h10004;
  localparam logic [17:0] W_FETCH1 = 18'h04802;
  localparam logic [17:0] W_JUMP   = 18'h01001;

  logic is_cond, cond_hit;
  assign is_cond  = (opcode == 4'hA) || (opcode == 4'hB) || (opcode == 4'hC);
  assign cond_hit = (opcode == 4'hA && flag_z) || (opcode == 4'hB && flag_s) ||
                    (opcode == 4'hC && flag_c);

  assert_fetch0_R4: assert property (@(posedge clk) disable iff (!rst_i)
    step == 2'd0 |-> ctrl == W_FETCH0);
  assert_fetch1_R4: assert property (@(posedge clk) disable iff (!rst_i)
    step == 2'd1 |-> ctrl == W_FETCH1);
  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !ctrl[17] |=> step == 2'($past(step) + 2'd1));
  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_i)
    ctrl[17] |=> $stable(step));
  assert_flag_ld_only_alu_R6: assert property (@(posedge clk) disable iff (!rst_i)
    ctrl[13] |-> (step == 2'd2 && (opcode == 4'h7 || opcode == 4'h8)));
  assert_cond_taken_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (cond_hit && step == 2'd2) |-> ctrl == W_JUMP);
  assert_cond_skip_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (is_cond && !cond_hit && step[1]) |-> ctrl == 18'h0);
endmodule

bind ucode_ctrl ucode_ctrl_chk u_chk (
  .clk(clk), .rst_i(rst_sync_n), .opcode(opcode), .flag_c(flag_c),
  .flag_s(flag_s), .flag_z(flag_z), .step(step), .ctrl(ctrl)
);

// File: tb/ucode_ctrl_test.sv
module ucode_ctrl_test;
  localparam int PERIOD = 10;

  localparam logic [17:0] K_HALT = 18'h1 << 17, K_MAR = 18'h1 << 16,
    K_RWR = 18'h1 << 15, K_RRD = 18'h1 << 14, K_FLG = 18'h1 << 13,
    K_IRO = 18'h1 << 12, K_IRL = 18'h1 << 11, K_OUT = 18'h1 << 10,
    K_SGN = 18'h1 << 9,  K_SUB = 18'h1 << 8,  K_ALU = 18'h1 << 7,
    K_BO  = 18'h1 << 6,  K_BL  = 18'h1 << 5,  K_AO  = 18'h1 << 4,
    K_AL  = 18'h1 << 3,  K_PCO = 18'h1 << 2,  K_PCI = 18'h1 << 1,
    K_PCL = 18'h1;

  typedef struct {
    logic [1:0]  st;
    logic [17:0] w;
    string       st_req;
    string       w_req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] opcode;
  logic flag_c, flag_s, flag_z;
  logic [1:0] step;
  logic [17:0] ctrl;

  int total = 0;
  int bad = 0;
  item_t sb[$];
  logic [1:0] m_step;
  int m_hold;
  logic m_prev_halt;

  always #(PERIOD/2) clk = ~clk;

  ucode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flag_c(flag_c),
    .flag_s(flag_s), .flag_z(flag_z), .step(step), .ctrl(ctrl)
  );

  function automatic logic [17:0] model(input logic [3:0] op, input logic [2:0] f,
                                        input logic [1:0] st);
    logic [3:0] e;
    e = op;
    if ((op == 4'hA && f[0]) || (op == 4'hB && f[1]) || (op == 4'hC && f[2])) e = 4'h9;
    if (st == 0) return K_PCO | K_MAR;
    if (st == 1) return K_RRD | K_IRL | K_PCI;
    if (st == 2) begin
      case (e)
        4'h1, 4'h3, 4'h5, 4'h6, 4'hD, 4'hE: return K_IRO | K_MAR;
        4'h2: return K_IRO | K_AL;
        4'h4: return K_IRO | K_BL;
        4'h7: return K_ALU | K_AL | K_FLG;
        4'h8: return K_ALU | K_SUB | K_AL | K_FLG;
        4'h9: return K_IRO | K_PCL;
        4'hF: return K_HALT;
        default: return 18'h0;
      endcase
    end
    case (e)
      4'h1: return K_RRD | K_AL;
      4'h3: return K_RRD | K_BL;
      4'h5: return K_AO | K_RWR;
      4'h6: return K_BO | K_RWR;
      4'hD: return K_RRD | K_OUT;
      4'hE: return K_RRD | K_OUT | K_SGN;
      default: return 18'h0;
    endcase
  endfunction

  function automatic string word_req(input logic [3:0] op, input logic [2:0] f,
                                     input logic [1:0] st);
    if (st < 2) return "R4";
    if (op == 4'h7 || op == 4'h8) return (f != 0) ? "R10" : "R6";
    if (op == 4'h9) return (f != 0) ? "R10" : "R7";
    if (op == 4'hA) return f[0] ? "R8" : "R9";
    if (op == 4'hB) return f[1] ? "R8" : "R9";
    if (op == 4'hC) return f[2] ? "R8" : "R9";
    return (f != 0) ? "R10" : "R5";
  endfunction

  // driver: entered and left at posedge + 1
  task automatic drive(input logic [3:0] op, input logic [2:0] f);
    item_t it;
    logic [17:0] w;
    opcode = op; {flag_c, flag_s, flag_z} = f;
    w = model(op, f, m_step);
    it.st = m_step; it.w = w; it.w_req = word_req(op, f, m_step);
    it.st_req = (m_hold > 0) ? "R1" : (m_prev_halt ? "R3" : "R2");
    sb.push_back(it);
    @(posedge clk); #1;
    m_prev_halt = w[17];
    if (m_hold > 0) m_hold--;
    else if (!w[17]) m_step = m_step + 2'd1;
  endtask

  task automatic run(input logic [3:0] op, input logic [2:0] f, input int n);
    for (int i = 0; i < n; i++) drive(op, f);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(step == it.st, it.st_req, "step", 18'(step), 18'(it.st));
      check(ctrl == it.w, it.w_req, "ctrl", ctrl, it.w);
    end
  end

  task automatic release_reset();
    rst_n = 1'b1; m_step = 2'd0; m_hold = 2; m_prev_halt = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    check(1'b0, "R2", "watchdog", 18'h0, 18'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 4'h7; {flag_c, flag_s, flag_z} = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    check(step == 2'd0, "R1", "step in reset", 18'(step), 18'h0);
    check(ctrl == (K_PCO | K_MAR), "R4", "ctrl in reset", ctrl, K_PCO | K_MAR);
    release_reset();
    run(4'h0, 3'b000, 4);
    // every opcode except halt, flags clear then all set
    for (int op = 0; op < 15; op++) run(4'(op), 3'b000, 4);
    for (int op = 0; op < 15; op++) run(4'(op), 3'b111, 4);
    // conditional jumps under all flag combinations
    for (int op = 10; op < 13; op++)
      for (int f = 0; f < 8; f++) run(4'(op), 3'(f), 4);
    // flags changing every cycle on ALU ops (R10)
    for (int i = 0; i < 8; i++) drive(4'h8, 3'(i));
    for (int i = 0; i < 8; i++) drive(4'hE, 3'(7 - i));
    // halt freezes, then a no-op resumes (R3)
    run(4'hF, 3'b000, 8);
    run(4'h0, 3'b000, 6);
    // asynchronous reset mid-instruction (R1)
    run(4'h1, 3'b000, 1);
    wait (sb.size() == 0);
    @(posedge clk); #1;
    m_step = m_step + 2'd1;
    rst_n = 1'b0;
    #1;
    check(step == 2'd0, "R1", "step after async reset", 18'(step), 18'h0);
    @(posedge clk); #1;
    release_reset();
    run(4'hB, 3'b010, 8);
    run(4'hC, 3'b011, 4);
    wait (sb.size() == 0);
    #(PERIOD);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule